// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block feeds a byte-oriented framer from a ring of transmit descriptors kept in a small descriptor memory. Each descriptor is one 64-bit word. It holds a status half-word, a byte count and a 32-bit buffer address. When the engine owns a descriptor, it reads that many bytes from the buffer memory. It presents the bytes on a valid/ready stream with start and end markers, so each buffer becomes one frame. It then either returns the descriptor to software or, in continuous mode, sends the same buffer again.

Software fills descriptors while the engine is disabled, programs the ring start index and a poll gap, and raises `enable`. The engine walks forward from the start index. A descriptor flagged as last sends the walk back to the start. A descriptor that software still holds is polled again after the gap; the engine never skips past it. Dropping `enable` lets any frame in flight finish, and the walk then restarts from the ring start.

Top module: `tx_ring_walker`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid`, `desc_rd_en`, `desc_wr_en` and `buf_rd_en` are 0.
- R2: A descriptor word is laid out as bits 63:48 status, bits 47:32 byte count and bits 31:0 buffer address. Status bit 15 is ready (1 = engine owns it), bit 13 is last and bit 12 is continuous.
- R3: A descriptor with count N > 0 produces exactly N stream bytes, taken from buffer addresses P to P+N-1 in order. `out_sof` is set on the first byte only and `out_eof` on byte N only.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_sof` and `out_eof` hold their values.
- R5: After the last byte of a non-continuous descriptor is accepted, the engine writes that descriptor's status exactly once, with bit 15 cleared and all other status bits unchanged. It never does so in the middle of a frame.
- R6: A descriptor fetched with ready clear causes no buffer read and no output. The same index is fetched again exactly `poll_gap`+3 cycles after the previous fetch.
- R7: After a descriptor is handed back, the next fetch is at the next index, or at the ring start if that descriptor had the last bit set.
- R8: A continuous descriptor is never written back. It is fetched again at the same index and sent again, giving repeated identical frames.
- R9: A descriptor with ready set and count 0 produces no bytes. It is written back with ready cleared, even if its continuous bit is set, and the walk advances.
- R10: A ring with a single descriptor that has the last bit set wraps back to that same descriptor.
- R11: When `enable` falls during a frame, the frame completes and its handoff still occurs. No further descriptor is fetched while disabled, and the next fetch after `enable` rises is at the ring start.
- R12: When `enable` rises, the first descriptor fetched is at index `ring_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows the ring walk |
| ring_base | input | DIDX_W | Index of the first descriptor in the ring |
| poll_gap | input | POLL_W | Extra wait before re-polling a descriptor software still holds |
| desc_rd_en | output | 1 | Descriptor read request |
| desc_rd_idx | output | DIDX_W | Descriptor read index |
| desc_rd_word | input | 16+LEN_W+PTR_W | Descriptor word, one cycle after the request |
| desc_wr_en | output | 1 | Status writeback strobe |
| desc_wr_idx | output | DIDX_W | Writeback index |
| desc_wr_status | output | 16 | Status half-word to store |
| buf_rd_en | output | 1 | Buffer byte read request |
| buf_rd_addr | output | PTR_W | Buffer byte address |
| buf_rd_byte | input | 8 | Buffer byte, one cycle after the request |
| out_valid | output | 1 | Stream byte valid |
| out_data | output | 8 | Stream byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Final byte of a frame |
| out_ready | input | 1 | Downstream accepts the byte |

## Verification
On every cycle, the assertions check that the stream stays stable under backpressure and that a start marker appears exactly when no frame is open. They also check that no descriptor is fetched or handed back while a frame is open, and that every writeback clears the ready bit. Only the bench scenarios can show the walk order, the wrap to the ring start, the exact re-poll spacing, the repetition of continuous frames, zero-count handling and the restart from the ring start after `enable` is toggled, because each of these needs memory contents and a history of fetches to judge.

// File: rtl/tx_ring_walker.sv
module tx_ring_walker #(
  parameter int DIDX_W = 4,
  parameter int LEN_W  = 16,
  parameter int PTR_W  = 32,
  parameter int POLL_W = 16,
  localparam int DESC_W = 16 + LEN_W + PTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [DIDX_W-1:0] ring_base,
  input  logic [POLL_W-1:0] poll_gap,
  output logic              desc_rd_en,
  output logic [DIDX_W-1:0] desc_rd_idx,
  input  logic [DESC_W-1:0] desc_rd_word,
  output logic              desc_wr_en,
  output logic [DIDX_W-1:0] desc_wr_idx,
  output logic [15:0]       desc_wr_status,
  output logic              buf_rd_en,
  output logic [PTR_W-1:0]  buf_rd_addr,
  input  logic [7:0]        buf_rd_byte,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_sof,
  output logic              out_eof,
  input  logic              out_ready
);
  localparam int RDY  = 15;
  localparam int LAST = 13;
  localparam int CONT = 12;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_POLL, S_RD, S_CAP, S_SEND, S_DONE} st_t;

  st_t               st;
  logic              running, first_q, err_q;
  logic [DIDX_W-1:0] cur, base_q;
  logic [15:0]       stat_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [LEN_W-1:0]  left;
  logic [POLL_W-1:0] poll_cnt;
  logic [7:0]        obyte;

  wire [15:0]       d_stat = desc_rd_word[DESC_W-1 -: 16];
  wire [LEN_W-1:0]  d_len  = desc_rd_word[PTR_W +: LEN_W];
  wire [PTR_W-1:0]  d_ptr  = desc_rd_word[PTR_W-1:0];
  wire              handoff = !stat_q[CONT] || err_q;
  wire              last_byte = (left == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      running  <= 1'b0;
      first_q  <= 1'b0;
      err_q    <= 1'b0;
      cur      <= '0;
      base_q   <= '0;
      stat_q   <= '0;
      ptr_q    <= '0;
      left     <= '0;
      poll_cnt <= '0;
      obyte    <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (!enable || !running) begin
            running <= enable;
            cur     <= ring_base;
            base_q  <= ring_base;
          end else begin
            st <= S_WAIT;
          end
        end
        S_WAIT: begin
          stat_q  <= d_stat;
          ptr_q   <= d_ptr;
          left    <= d_len;
          first_q <= 1'b1;
          err_q   <= (d_len == '0);
          if (!enable)            st <= S_IDLE;
          else if (!d_stat[RDY]) begin
            poll_cnt <= poll_gap;
            st       <= S_POLL;
          end
          else if (d_len == '0)   st <= S_DONE;
          else                    st <= S_RD;
        end
        S_POLL: begin
          if (!enable || poll_cnt == '0) st <= S_IDLE;
          else poll_cnt <= poll_cnt - 1'b1;
        end
        S_RD: st <= S_CAP;
        S_CAP: begin
          obyte <= buf_rd_byte;
          st    <= S_SEND;
        end
        S_SEND: begin
          if (out_ready) begin
            first_q <= 1'b0;
            left    <= left - 1'b1;
            ptr_q   <= ptr_q + 1'b1;
            st      <= last_byte ? S_DONE : S_RD;
          end
        end
        S_DONE: begin
          if (handoff) cur <= stat_q[LAST] ? base_q : cur + 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign desc_rd_en     = (st == S_IDLE) && enable && running;
  assign desc_rd_idx    = cur;
  assign desc_wr_en     = (st == S_DONE) && handoff;
  assign desc_wr_idx    = cur;
  assign desc_wr_status = {1'b0, stat_q[14:0]};
  assign buf_rd_en      = (st == S_RD);
  assign buf_rd_addr    = ptr_q;
  assign out_valid      = (st == S_SEND);
  assign out_data       = obyte;
  assign out_sof        = out_valid && first_q;
  assign out_eof        = out_valid && last_byte;
endmodule

// File: rtl/tx_ring_walker_chk.sv
module tx_ring_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  out_data,
  input logic        out_sof,
  input logic        out_eof,
  input logic        desc_rd_en,
  input logic        desc_wr_en,
  input logic [15:0] desc_wr_status,
  input logic        buf_rd_en
);
  logic in_frame;

  always_ff @(posedge clk) begin
    if (!rst_n) in_frame <= 1'b0;
    else if (out_valid && out_ready) in_frame <= !out_eof;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !desc_rd_en && !desc_wr_en && !buf_rd_en));

  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof)));

  assert_sof_at_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sof == !in_frame));

  assert_handoff_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr_en |-> (!in_frame && !desc_wr_status[15]));

  assert_no_fetch_midframe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    desc_rd_en |-> (!in_frame && !out_valid));
endmodule

bind tx_ring_walker tx_ring_walker_chk chk_i (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
  .desc_rd_en(desc_rd_en), .desc_wr_en(desc_wr_en),
  .desc_wr_status(desc_wr_status), .buf_rd_en(buf_rd_en)
);

// File: tb/tx_ring_walker_tb_top.sv
module tx_ring_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [3:0]  ring_base = '0;
  logic [15:0] poll_gap = '0;
  logic        desc_rd_en, desc_wr_en, buf_rd_en;
  logic [3:0]  desc_rd_idx, desc_wr_idx;
  logic [63:0] desc_rd_word = '0;
  logic [15:0] desc_wr_status;
  logic [31:0] buf_rd_addr;
  logic [7:0]  buf_rd_byte = '0;
  logic        out_valid, out_sof, out_eof;
  logic [7:0]  out_data;
  logic        out_ready = 1'b0;

  always #5 clk = ~clk;

  tx_ring_walker dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ring_base(ring_base), .poll_gap(poll_gap),
    .desc_rd_en(desc_rd_en), .desc_rd_idx(desc_rd_idx), .desc_rd_word(desc_rd_word),
    .desc_wr_en(desc_wr_en), .desc_wr_idx(desc_wr_idx), .desc_wr_status(desc_wr_status),
    .buf_rd_en(buf_rd_en), .buf_rd_addr(buf_rd_addr), .buf_rd_byte(buf_rd_byte),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
    .out_ready(out_ready)
  );

  function automatic logic [7:0] bval(input logic [31:0] a);
    return a[7:0] * 8'd5 + a[15:8] + 8'h3B;
  endfunction

  function automatic logic [63:0] mk(input bit rdy, input bit last, input bit cont,
                                     input logic [15:0] len, input logic [31:0] ptr);
    return {rdy, 1'b0, last, cont, 12'h000, len, ptr};
  endfunction

  logic        sw_we = 1'b0;
  logic [3:0]  sw_idx = '0;
  logic [63:0] sw_word = '0;
  logic [63:0] dmem [0:15];

  always @(posedge clk) begin
    if (sw_we) dmem[sw_idx] <= sw_word;
    if (desc_wr_en) dmem[desc_wr_idx][63:48] <= desc_wr_status;
    if (desc_rd_en) desc_rd_word <= dmem[desc_rd_idx];
    if (buf_rd_en) buf_rd_byte <= bval(buf_rd_addr);
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int rmode = 0;
  int nacc = 0, nfetch = 0, nwr = 0, hold_bad = 0;
  logic [7:0]  acc_d [0:1023];
  logic        acc_s [0:1023];
  logic        acc_e [0:1023];
  int          f_idx [0:255];
  int          f_cyc [0:255];
  int          w_idx [0:63];
  logic [15:0] w_st  [0:63];
  logic        held = 1'b0;
  logic [7:0]  held_d = '0;

  always @(negedge clk) begin
    logic r;
    case (rmode)
      0:       r = 1'b1;
      1:       r = (cyc % 2) == 0;
      default: r = (cyc % 3) != 0;
    endcase
    out_ready = r;
    if (held && (!out_valid || out_data != held_d)) hold_bad++;
    held   = out_valid && !r;
    held_d = out_data;
    if (out_valid && r && nacc < 1024) begin
      acc_d[nacc] = out_data; acc_s[nacc] = out_sof; acc_e[nacc] = out_eof; nacc++;
    end
    if (desc_rd_en && nfetch < 256) begin
      f_idx[nfetch] = int'(desc_rd_idx); f_cyc[nfetch] = cyc; nfetch++;
    end
    if (desc_wr_en && nwr < 64) begin
      w_idx[nwr] = int'(desc_wr_idx); w_st[nwr] = desc_wr_status; nwr++;
    end
  end

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sw(input int i, input logic [63:0] w);
    @(negedge clk); sw_we = 1'b1; sw_idx = 4'(i); sw_word = w;
    @(negedge clk); sw_we = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_frame(input int at, input logic [31:0] p, input int len, input string req);
    int errs = 0;
    for (int j = 0; j < len; j++) begin
      if (acc_d[at+j] != bval(p + 32'(j))) errs++;
      if (acc_s[at+j] != (j == 0)) errs++;
      if (acc_e[at+j] != (j == len-1)) errs++;
    end
    chk(errs == 0, req, errs, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end

  initial begin
    int a0, f0, w0, f1, n, e;
    settle(3);
    chk(!out_valid && !desc_rd_en && !desc_wr_en && !buf_rd_en, "R1 in reset", int'(out_valid), 0);
    for (int i = 0; i < 16; i++) sw(i, 64'h0);
    rst_n = 1'b1;
    settle(4);
    chk(!out_valid && !desc_rd_en && !desc_wr_en && !buf_rd_en, "R1 after release", int'(desc_rd_en), 0);

    // Ring 2..4, backpressure on alternate cycles, gap 5
    ring_base = 4'd2; poll_gap = 16'd5; rmode = 1;
    sw(2, mk(1, 0, 0, 16'd3, 32'h0000_0100));
    sw(3, mk(1, 0, 0, 16'd1, 32'h0000_2000));
    sw(4, mk(1, 1, 0, 16'd5, 32'h0001_0030));
    a0 = nacc; f0 = nfetch; w0 = nwr;
    enable = 1'b1;
    while (nfetch < f0 + 7) @(negedge clk);
    enable = 1'b0;
    settle(20);
    chk(nacc - a0 == 9, "R3 byte total", nacc - a0, 9);
    check_frame(a0,     32'h0000_0100, 3, "R2 R3 frame0");
    check_frame(a0 + 3, 32'h0000_2000, 1, "R3 frame1 single byte");
    check_frame(a0 + 4, 32'h0001_0030, 5, "R3 frame2");
    chk(f_idx[f0] == 2, "R12 first fetch at base", f_idx[f0], 2);
    chk(f_idx[f0+1] == 3 && f_idx[f0+2] == 4, "R7 step", f_idx[f0+2], 4);
    chk(f_idx[f0+3] == 2, "R7 wrap after last", f_idx[f0+3], 2);
    e = 0;
    for (int k = 3; k < 7; k++) if (f_idx[f0+k] != 2) e++;
    chk(e == 0, "R6 no skip past held descriptor", e, 0);
    chk(f_cyc[f0+5] - f_cyc[f0+4] == 8, "R6 poll spacing", f_cyc[f0+5] - f_cyc[f0+4], 8);
    chk(f_cyc[f0+6] - f_cyc[f0+5] == 8, "R6 poll spacing again", f_cyc[f0+6] - f_cyc[f0+5], 8);
    chk(nwr - w0 == 3, "R5 handoff count", nwr - w0, 3);
    chk(w_idx[w0] == 2 && w_st[w0] == 16'h0000, "R5 handoff 0", int'(w_st[w0]), 0);
    chk(w_idx[w0+1] == 3 && w_st[w0+1] == 16'h0000, "R5 handoff 1", w_idx[w0+1], 3);
    chk(w_idx[w0+2] == 4 && w_st[w0+2] == 16'h2000, "R5 handoff keeps last bit", int'(w_st[w0+2]), 'h2000);
    chk(hold_bad == 0, "R4 hold under backpressure", hold_bad, 0);

    // Single continuous descriptor
    ring_base = 4'd0; poll_gap = 16'd0; rmode = 2;
    sw(0, mk(1, 1, 1, 16'd4, 32'h0000_0055));
    a0 = nacc; f0 = nfetch; w0 = nwr;
    enable = 1'b1;
    while (nacc < a0 + 12) @(negedge clk);
    enable = 1'b0;
    settle(40);
    n = nacc - a0;
    chk(n % 4 == 0 && n >= 12, "R8 whole repeated frames", n, 12);
    e = 0;
    for (int k = 0; k < n / 4; k++) begin
      for (int j = 0; j < 4; j++) begin
        if (acc_d[a0+4*k+j] != bval(32'h55 + 32'(j))) e++;
        if (acc_s[a0+4*k+j] != (j == 0) || acc_e[a0+4*k+j] != (j == 3)) e++;
      end
    end
    chk(e == 0, "R8 identical frames", e, 0);
    chk(nwr == w0, "R8 no handoff", nwr - w0, 0);
    e = 0;
    for (int k = f0; k < nfetch; k++) if (f_idx[k] != 0) e++;
    chk(e == 0 && nfetch - f0 >= 3, "R10 single ring wraps to itself", e, 0);
    chk(hold_bad == 0, "R4 hold under sparse ready", hold_bad, 0);

    // Zero count (with continuous flag) then a last descriptor
    ring_base = 4'd5; poll_gap = 16'd3; rmode = 0;
    sw(5, mk(1, 0, 1, 16'd0, 32'h0000_0400));
    sw(6, mk(1, 1, 0, 16'd2, 32'h0000_0700));
    a0 = nacc; w0 = nwr;
    enable = 1'b1;
    while (nwr < w0 + 2) @(negedge clk);
    enable = 1'b0;
    settle(20);
    chk(nacc - a0 == 2, "R9 zero count sends nothing", nacc - a0, 2);
    check_frame(a0, 32'h0000_0700, 2, "R9 next descriptor sent");
    chk(w_idx[w0] == 5 && w_st[w0] == 16'h1000, "R9 zero count handed back", int'(w_st[w0]), 'h1000);
    chk(w_idx[w0+1] == 6 && w_st[w0+1] == 16'h2000, "R9 walk advanced", w_idx[w0+1], 6);

    // Enable drop mid-frame
    ring_base = 4'd8; poll_gap = 16'd2; rmode = 1;
    sw(8, mk(1, 0, 0, 16'd10, 32'h0000_0900));
    sw(9, mk(1, 1, 0, 16'd2,  32'h0000_0A00));
    a0 = nacc; f0 = nfetch; w0 = nwr;
    enable = 1'b1;
    while (nacc < a0 + 3) @(negedge clk);
    enable = 1'b0;
    settle(60);
    chk(nacc - a0 == 10, "R11 frame completes", nacc - a0, 10);
    check_frame(a0, 32'h0000_0900, 10, "R11 frame content");
    chk(nwr - w0 == 1 && w_idx[w0] == 8, "R11 handoff still occurs", nwr - w0, 1);
    e = 0;
    for (int k = f0; k < nfetch; k++) if (f_idx[k] == 9) e++;
    chk(e == 0, "R11 no fetch while disabled", e, 0);
    f1 = nfetch;
    enable = 1'b1;
    while (nfetch < f1 + 1) @(negedge clk);
    chk(f_idx[f1] == 8, "R11 restart at ring start", f_idx[f1], 8);
    enable = 1'b0;
    settle(20);
    chk(hold_bad == 0, "R4 hold final", hold_bad, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule